// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Idle-Line Resynchronization

This block takes an asynchronous serial line and recovers 8-bit characters. Each character has one start bit, eight data bits sent least significant first, and one stop bit, with no parity. Timing comes from a free-running tick counter clocked by the core clock. Sample points are set by equality compares against that counter. Two runtime inputs set the timing: the length of one bit in ticks, and the delay from the start edge to the middle of the first data bit.

The receiver checks the line again half a bit after the start edge. If the line is no longer low at that point, it treats the pulse as a glitch and goes back to hunting for a start bit. Each later sample is placed one bit length after the previous scheduled sample, not after the time the sample was actually taken, so rounding errors do not accumulate.

When the stop bit is good, the character is loaded into a holding register and a ready strobe is raised for one cycle. When the stop bit is bad, the character is dropped and a framing-error strobe is raised for one cycle. The receiver then waits for the line to return high before it looks for another start bit. The frame state is brought out so that a controller can watch progress through the character.

Top module: `uart_rx_resync`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, state_o is 10 (waiting for an idle-high line), and ready_o and frame_err_o are 0.
- R2: State code 10 moves to code 0 (hunting for a start bit) only after the synchronized line reads 1. A line held low keeps state_o at 10.
- R3: rx_i passes through two flip-flops before the frame logic uses it. A rising level applied while state_o is 10 leaves state_o at 10 for two clock edges and changes it to 0 on the third edge.
- R4: In state 0, a low line starts a check at floor(bit_ticks_i/2) ticks later. If the line is high at that point, no character is produced and state_o stays 0.
- R5: A confirmed start bit sets state_o to 1. The first data sample is taken bit15_ticks_i ticks after the start edge, and each later sample is taken bit_ticks_i ticks after the previous scheduled sample. Data sample k, with k from 1 to 8, raises state_o from k to k+1, and state code 9 means the next sample is the stop bit. Both delays can be changed at runtime while the receiver is hunting.
- R6: Data is received least significant bit first, so bit 0 of data_o holds the first data bit received.
- R7: A stop sample of 1 loads the received byte into data_o, raises ready_o for exactly one cycle, and returns state_o to 0.
- R8: A stop sample of 0 raises frame_err_o for exactly one cycle, leaves data_o unchanged, does not raise ready_o, and sets state_o to 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock; the reference tick counter advances on every cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Asynchronous serial line |
| bit_ticks_i | input | TICK_W | Length of one bit, in ticks |
| bit15_ticks_i | input | TICK_W | Delay from the start edge to the first data sample, in ticks |
| data_o | output | 8 | Last byte received with a good stop bit |
| ready_o | output | 1 | One-cycle strobe when data_o is loaded |
| frame_err_o | output | 1 | One-cycle strobe when the stop bit is bad |
| state_o | output | 4 | Current frame state code |

## Verification
The assertions assume that bit_ticks_i is at least 2 and that bit15_ticks_i is larger than half of bit_ticks_i. Under those conditions every scheduled compare lies in the future and is met before the counter wraps. They also assume that each level on rx_i lasts much longer than the synchronizer delay. The stimulus keeps both delays fixed during a frame and changes them only while the receiver is hunting. It holds each level for a whole number of bit lengths, except for the deliberate short low pulse that exercises glitch rejection. The bit length is 16 or 10 ticks, so the mid-bit points sit well away from the level changes.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned DATA_BITS = 8;
  localparam int unsigned ST_W      = $clog2(DATA_BITS + 3);
  typedef logic [ST_W-1:0] rx_state_t;
  localparam rx_state_t ST_HUNT  = rx_state_t'(0);
  localparam rx_state_t ST_FIRST = rx_state_t'(1);
  localparam rx_state_t ST_STOP  = rx_state_t'(DATA_BITS + 1);
  localparam rx_state_t ST_IDLE  = rx_state_t'(DATA_BITS + 2);
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     stage_q[i] <= 1'b0;
        else if (i == 0) stage_q[i] <= d_i;
        else             stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
  parameter int unsigned TICK_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [TICK_W-1:0] tick_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_o <= '0;
    else         tick_o <= tick_o + 1'b1;
  end
endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
  import uart_rx_pkg::*;
#(
  parameter int unsigned TICK_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 line_i,
  input  logic [TICK_W-1:0]    tick_i,
  input  logic [TICK_W-1:0]    bit_ticks_i,
  input  logic [TICK_W-1:0]    bit15_ticks_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 ready_o,
  output logic                 frame_err_o,
  output rx_state_t            state_o
);
  rx_state_t           state_q;
  logic                chk_q;
  logic [TICK_W-1:0]   edge_q, due_q;
  logic [DATA_BITS-1:0] shift_q, data_q;
  logic                ready_q, err_q;
  logic                hit;
  logic [TICK_W-1:0]   half_ticks;

  assign hit        = (tick_i == due_q);
  assign half_ticks = bit_ticks_i >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      chk_q   <= 1'b0;
      edge_q  <= '0;
      due_q   <= '0;
      shift_q <= '0;
      data_q  <= '0;
      ready_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      ready_q <= 1'b0;
      err_q   <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (line_i) state_q <= ST_HUNT;
      end else if (state_q == ST_HUNT) begin
        if (!chk_q) begin
          if (!line_i) begin
            chk_q  <= 1'b1;
            edge_q <= tick_i;
            due_q  <= tick_i + half_ticks;
          end
        end else if (hit) begin
          chk_q <= 1'b0;
          // glitch rejection: line must still be low mid start bit
          if (!line_i) begin
            state_q <= ST_FIRST;
            shift_q <= '0;
            due_q   <= edge_q + bit15_ticks_i;
          end
        end
      end else if (state_q == ST_STOP) begin
        if (hit) begin
          if (line_i) begin
            data_q  <= shift_q;
            ready_q <= 1'b1;
            state_q <= ST_HUNT;
          end else begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
      end else if (hit) begin
        shift_q <= {line_i, shift_q[DATA_BITS-1:1]};
        state_q <= state_q + 1'b1;
        // next point from scheduled time, not from actual sample
        due_q   <= due_q + bit_ticks_i;
      end
    end
  end

  assign data_o      = data_q;
  assign ready_o     = ready_q;
  assign frame_err_o = err_q;
  assign state_o     = state_q;

  // R7
  ready_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (state_o == ST_HUNT && $past(state_o) == ST_STOP));
  // R7
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  // R8
  err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> (state_o == ST_IDLE && $past(state_o) == ST_STOP));
  // R8
  err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && frame_err_o));
  // R8
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> $stable(data_o));
  // R5
  data_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_o) >= ST_FIRST && $past(state_o) < ST_STOP && state_o != $past(state_o))
      |-> (state_o == $past(state_o) + 1'b1));
  // R2
  idle_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_o) == ST_IDLE && state_o != ST_IDLE) |-> (state_o == ST_HUNT && $past(line_i)));
  // R4
  hunt_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_o) == ST_HUNT && state_o != ST_HUNT) |-> state_o == ST_FIRST);
endmodule

// File: rtl/uart_rx_resync.sv
module uart_rx_resync
  import uart_rx_pkg::*;
#(
  parameter int unsigned TICK_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rx_i,
  input  logic [TICK_W-1:0]    bit_ticks_i,
  input  logic [TICK_W-1:0]    bit15_ticks_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 ready_o,
  output logic                 frame_err_o,
  output logic [ST_W-1:0]      state_o
);
  logic              line_s;
  logic [TICK_W-1:0] tick;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (line_s)
  );

  uart_rx_tick #(.TICK_W(TICK_W)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  uart_rx_fsm #(.TICK_W(TICK_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_i       (line_s),
    .tick_i       (tick),
    .bit_ticks_i  (bit_ticks_i),
    .bit15_ticks_i(bit15_ticks_i),
    .data_o       (data_o),
    .ready_o      (ready_o),
    .frame_err_o  (frame_err_o),
    .state_o      (state_o)
  );
endmodule

// File: tb/uart_rx_resync_test.sv
module uart_rx_resync_test;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          rx = 1'b0;
  logic [TW-1:0] bit_t = 16'd16;
  logic [TW-1:0] b15_t = 16'd24;
  logic [7:0]    data;
  logic          ready, ferr;
  logic [3:0]    state;

  int total = 0, failed = 0;
  int ready_cnt = 0, err_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_rx_resync #(.TICK_W(TW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_i(rx),
    .bit_ticks_i(bit_t), .bit15_ticks_i(b15_t),
    .data_o(data), .ready_o(ready), .frame_err_o(ferr), .state_o(state)
  );

  always @(negedge clk) begin
    if (ready) ready_cnt++;
    if (ferr)  err_cnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drives one frame; probe checks state_o mid-frame (bit length 16).
  task automatic send_frame(input logic [7:0] b, input bit stop_v, input int bt, input bit probe);
    rx = 1'b0;
    wait_cyc(bt);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      if (probe && i == 4) begin
        wait_cyc(3);
        check("R5 state after four samples", state, 5);
        wait_cyc(bt - 3);
      end else begin
        wait_cyc(bt);
      end
    end
    rx = stop_v;
    wait_cyc(bt);
    if (stop_v) rx = 1'b1;
  endtask

  task automatic t_reset();
    wait_cyc(3);
    check("R1 state in reset", state, 10);
    check("R1 ready in reset", ready, 0);
    check("R1 ferr in reset", ferr, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 state after release", state, 10);
    wait_cyc(40);
    check("R2 low line keeps idle wait", state, 10);
  endtask

  task automatic t_sync();
    rx = 1'b1;
    wait_cyc(2);
    check("R3 two edges after rise", state, 10);
    wait_cyc(1);
    check("R3 third edge after rise", state, 0);
    wait_cyc(20);
    check("R2 hunting on idle high", state, 0);
  endtask

  task automatic t_byte(input logic [7:0] b, input int bt, input bit probe);
    int r0 = ready_cnt;
    send_frame(b, 1'b1, bt, probe);
    wait_cyc(2 * bt);
    check("R7 one ready pulse", ready_cnt - r0, 1);
    check("R6 data byte", data, b);
    check("R7 back to hunting", state, 0);
  endtask

  task automatic t_glitch();
    int r0 = ready_cnt;
    rx = 1'b0;
    wait_cyc(4);
    rx = 1'b1;
    wait_cyc(48);
    check("R4 glitch gives no byte", ready_cnt - r0, 0);
    check("R4 glitch state hunting", state, 0);
  endtask

  task automatic t_frame_err();
    int r0 = ready_cnt;
    int e0 = err_cnt;
    logic [7:0] prev = data;
    send_frame(8'h6E, 1'b0, 16, 1'b0);
    wait_cyc(48);
    check("R8 one error pulse", err_cnt - e0, 1);
    check("R8 no ready", ready_cnt - r0, 0);
    check("R8 data unchanged", data, prev);
    check("R8 waiting for idle", state, 10);
    rx = 1'b1;
    wait_cyc(8);
    check("R2 idle line resumes hunting", state, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  initial begin
    t_reset();
    t_sync();
    t_byte(8'hA5, 16, 1'b1);
    t_byte(8'h01, 16, 1'b0);
    t_byte(8'h80, 16, 1'b0);
    t_byte(8'h00, 16, 1'b0);
    t_byte(8'hFF, 16, 1'b0);
    t_glitch();
    t_byte(8'h5A, 16, 1'b0);
    t_frame_err();
    t_byte(8'hC3, 16, 1'b0);
    bit_t = 16'd10;
    b15_t = 16'd15;
    wait_cyc(4);
    t_byte(8'h3C, 10, 1'b0);
    t_byte(8'h96, 10, 1'b0);
    done = 1'b1;
    finish_run();
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog: actual running expected done");
      finish_run();
    end
  end
endmodule